// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

A memory-mapped timer bank with several independent down-counting channels. Each channel owns a 32-bit reload value, a 32-bit live count and a 16-bit control word. A single 8-bit run register is shared by all channels and holds one run bit per channel. While its bit is set, a channel decrements its count once per prescaled period of the input clock. When a decrement would go below zero, the count is reloaded from the reload value, an underflow flag is latched, and the channel's interrupt line rises if it is enabled.

Each channel is a two-state machine. In HALT the count and the prescaler hold still. The transition HALT->RUN is taken on the clock edge after the channel's run bit is seen set. In RUN the prescaler advances. The transition RUN->HALT is taken on the edge after the run bit is seen clear, and it clears the prescaler phase. Software obtains a rising count by inverting the count value. A reload value of all ones gives the longest period, and a smaller value gives periodic events every (reload+1) prescaled ticks.

The bus port is single-cycle. Writes take effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the run register reads 0, each channel's reload and count read 0xFFFFFFFF, each control word reads 0, and every interrupt output is low.
- R2: Address map, word aligned (addr[1:0] must be 0): the run register is at 0x00. Channel c has its base at 0x10*(c+1), with the reload value at base+0x0, the count at base+0x4 and the control word at base+0x8. The control word reads back only bit 8 (underflow flag), bit 5 (interrupt enable) and bits [2:0] (rate select), with all other bits 0. The run register reads back only bits [NUM_CH-1:0]. Unmapped addresses read 0.
- R3: Run bit c runs channel c alone. A channel whose run bit is clear keeps its count unchanged, whatever the other channels do.
- R4: Bits [2:0] of the control word select the divisor D: 000=4, 001=16, 010=64, 011=256, any other value=4. If the run bit is set on edge a and cleared on edge b, the channel takes exactly floor((b-a)/D) count steps.
- R5: A count step taken at count 0 loads the reload value and sets the underflow flag (bit 8). Any other step subtracts 1.
- R6: A write to the count register while the channel is halted loads it directly, and counting resumes from that value once the channel runs.
- R7: A control write with bit 8 at 0 clears the underflow flag. A control write with bit 8 at 1 leaves the flag unchanged. An underflow in the same cycle as a control write sets the flag. Writing 0x0020 therefore acknowledges the flag and keeps the interrupt enabled, and writing 0x0000 clears both the flag and the enable.
- R8: Interrupt output c is high exactly while channel c has both its underflow flag and its interrupt enable set. It stays high until software clears one of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | NUM_CH (3) | Per-channel level interrupt |

## Verification
Directed cases cover the reset state, the readback masks and an underflow from a small preloaded count. The directed cases also walk the flag through acknowledge-with-1, acknowledge-with-0x0020 and clear-with-0x0000, so the flag and enable behaviours can be told apart. Random rounds then pick a rate select for two channels at once, including the undefined codes. Each round also picks a short reload value, a preload written while halted, an interrupt enable and a run interval. The final count and the latched flag separate a wrong divisor, an off-by-one in the step window, and a wrong reload or wrap point. A third channel is never started, so any leakage between run bits shows up as a change in its count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {CH_HALT, CH_RUN} ch_state_e;

    localparam int CNT_W      = 32;
    localparam int CTL_W      = 16;
    localparam int RUN_W      = 8;
    localparam int PRE_W      = 8;
    localparam int FLAG_BIT   = 8;
    localparam int IEN_BIT    = 5;
    localparam int SEL_W      = 3;

    localparam logic [1:0] IDX_RELOAD = 2'd0;
    localparam logic [1:0] IDX_COUNT  = 2'd1;
    localparam logic [1:0] IDX_CTRL   = 2'd2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        case (sel)
            3'd1:    limit = PRE_W'(15);
            3'd2:    limit = PRE_W'(63);
            3'd3:    limit = PRE_W'(255);
            default: limit = PRE_W'(3);
        endcase
    end

    assign tick = active && (phase_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (!active || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + PRE_W'(1);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             we_reload,
    input  logic             we_count,
    input  logic             we_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             irq_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] reload_q, count_q;
    logic [SEL_W-1:0] sel_q;
    logic             ien_q, flag_q;
    logic             tick, uflow;

    tmr_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == CH_RUN),
        .sel    (sel_q),
        .tick   (tick)
    );

    assign uflow = tick && (count_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (run_i)  state_d = CH_RUN;
            CH_RUN:  if (!run_i) state_d = CH_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '1;
            count_q  <= '1;
            sel_q    <= '0;
            ien_q    <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (we_reload) reload_q <= wdata;
            if (we_count)
                count_q <= wdata;
            else if (uflow)
                count_q <= reload_q;
            else if (tick)
                count_q <= count_q - CNT_W'(1);
            if (we_ctrl) begin
                sel_q <= wdata[SEL_W-1:0];
                ien_q <= wdata[IEN_BIT];
            end
            if (uflow)
                flag_q <= 1'b1;
            else if (we_ctrl && !wdata[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        reload_o = reload_q;
        count_o  = count_q;
        ctrl_o   = '0;
        ctrl_o[SEL_W-1:0] = sel_q;
        ctrl_o[IEN_BIT]   = ien_q;
        ctrl_o[FLAG_BIT]  = flag_q;
        irq_o    = flag_q && ien_q;
    end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int SLOT_W = ADDR_W - 4;
    localparam logic [RUN_W-1:0] RUN_MASK = RUN_W'((1 << NUM_CH) - 1);

    logic [RUN_W-1:0]  run_q;
    logic [CNT_W-1:0]  cst_v [NUM_CH];
    logic [CNT_W-1:0]  cnt_v [NUM_CH];
    logic [CTL_W-1:0]  ctl_v [NUM_CH];
    logic [SLOT_W-1:0] slot;
    logic [1:0]        idx;
    logic              aligned, hit_run;

    assign slot    = bus_addr[ADDR_W-1:4];
    assign idx     = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign hit_run = (bus_addr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_q <= '0;
        else if (bus_we && hit_run) run_q <= bus_wdata[RUN_W-1:0] & RUN_MASK;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_ch;
        assign sel_ch = aligned && (slot == SLOT_W'(c + 1));
        tmr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run_q[c]),
            .we_reload (bus_we && sel_ch && idx == IDX_RELOAD),
            .we_count  (bus_we && sel_ch && idx == IDX_COUNT),
            .we_ctrl   (bus_we && sel_ch && idx == IDX_CTRL),
            .wdata     (bus_wdata),
            .reload_o  (cst_v[c]),
            .count_o   (cnt_v[c]),
            .ctrl_o    (ctl_v[c]),
            .irq_o     (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_run) bus_rdata = CNT_W'(run_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (aligned && slot == SLOT_W'(c + 1)) begin
                case (idx)
                    IDX_RELOAD: bus_rdata = cst_v[c];
                    IDX_COUNT:  bus_rdata = cnt_v[c];
                    IDX_CTRL:   bus_rdata = CNT_W'(ctl_v[c]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] irq,
    input logic [RUN_W-1:0]  run_q,
    input logic [CNT_W-1:0]  cst_v [NUM_CH],
    input logic [CNT_W-1:0]  cnt_v [NUM_CH],
    input logic [CTL_W-1:0]  ctl_v [NUM_CH]
);
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (run_q == '0 && irq == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic wr_cst, wr_cnt, wr_ctl;
        assign wr_cst = bus_we && bus_addr == ADDR_W'((c + 1) * 16);
        assign wr_cnt = bus_we && bus_addr == ADDR_W'((c + 1) * 16 + 4);
        assign wr_ctl = bus_we && bus_addr == ADDR_W'((c + 1) * 16 + 8);

        p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[c] && $past(!run_q[c]) && !wr_cnt) |=> $stable(cnt_v[c]));

        p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_cnt && cnt_v[c] != '0) |=>
                (cnt_v[c] == $past(cnt_v[c]) || cnt_v[c] == $past(cnt_v[c]) - CNT_W'(1)));

        p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_v[c] == '0 && !wr_cnt && !wr_cst) |=>
                (cnt_v[c] == '0 || (cnt_v[c] == $past(cst_v[c]) && ctl_v[c][FLAG_BIT])));

        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_v[c][FLAG_BIT] && !wr_ctl) |=> ctl_v[c][FLAG_BIT]);

        p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[c] && !wr_ctl) |=> irq[c]);
    end
endmodule

bind tick_timer_bank tmr_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq      (irq),
    .run_q    (run_q),
    .cst_v    (cst_v),
    .cnt_v    (cnt_v),
    .ctl_v    (ctl_v)
);

// File: tb/tb_tick_timer_bank.sv
`timescale 1ns/1ps
module tb_tick_timer_bank;
    localparam int NUM_CH = 3;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    tick_timer_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] a_reg(int ch, int idx);
        return 8'((ch + 1) * 16 + idx * 4);
    endfunction

    function automatic longint divisor(int sel);
        case (sel)
            1: return 16;
            2: return 64;
            3: return 256;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] exp_count(longint s, longint c, longint t);
        if (t <= s) return 32'(s - t);
        return 32'(c - ((t - s - 1) % (c + 1)));
    endfunction

    function automatic longint exp_uflows(longint s, longint c, longint t);
        if (t <= s) return 0;
        return 1 + (t - s - 1) / (c + 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int m);
        repeat (m) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, hold1;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v);         check("R1 run", v, 32'h0);
        rd(a_reg(0, 0), v);   check("R1 reload", v, 32'hFFFF_FFFF);
        rd(a_reg(2, 1), v);   check("R1 count", v, 32'hFFFF_FFFF);
        rd(a_reg(1, 2), v);   check("R1 ctrl", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 map and readback masks
        wr(a_reg(1, 0), 32'h1234_5678);
        rd(a_reg(1, 0), v);   check("R2 reload readback", v, 32'h1234_5678);
        wr(a_reg(1, 2), 32'h0000_FFFF);
        rd(a_reg(1, 2), v);   check("R2 ctrl mask", v, 32'h0000_0027);
        rd(8'h44, v);         check("R2 unmapped", v, 32'h0);
        wr(8'h00, 32'h0000_00FF);
        rd(8'h00, v);         check("R2 run mask", v, 32'h0000_0007);
        wr(8'h00, 32'h0);
        wr(a_reg(1, 2), 32'h0);

        // R6 load while halted, R5 underflow, R3 channel 1 stays idle
        wr(a_reg(1, 1), 32'h0000_0ABC);
        wr(a_reg(0, 0), 32'd3);
        wr(a_reg(0, 1), 32'd1);
        rd(a_reg(0, 1), v);   check("R6 halted load", v, 32'd1);
        wr(a_reg(0, 2), 32'h0000_0020);
        wr(8'h00, 32'h1);
        idle(18);
        wr(8'h00, 32'h0);     // 20 edges -> 5 steps at /4
        rd(a_reg(0, 1), v);   check("R5 reload count", v, exp_count(1, 3, 5));
        rd(a_reg(0, 2), v);   check("R5 flag set", v, 32'h0000_0120);
        check("R8 irq high", 32'(irq[0]), 32'h1);
        rd(a_reg(1, 1), v);   check("R3 idle channel held", v, 32'h0000_0ABC);

        // R7 flag write semantics
        wr(a_reg(0, 2), 32'h0000_0120);
        rd(a_reg(0, 2), v);   check("R7 write one keeps flag", v, 32'h0000_0120);
        check("R8 irq held", 32'(irq[0]), 32'h1);
        wr(a_reg(0, 2), 32'h0000_0020);
        rd(a_reg(0, 2), v);   check("R7 ack keeps enable", v, 32'h0000_0020);
        check("R8 irq after ack", 32'(irq[0]), 32'h0);
        wr(a_reg(0, 2), 32'h0);
        rd(a_reg(0, 2), v);   check("R7 clear all", v, 32'h0);

        // random rounds on channels 0 and 2; channel 1 never runs
        rd(a_reg(1, 1), hold1);
        for (int it = 0; it < 40; it++) begin
            int sel0, sel2, m;
            bit en0, en2;
            longint c0, c2, s0, s2, t0, t2, u0, u2;
            logic [31:0] ctl0, ctl2;
            sel0 = int'($urandom_range(0, 7)); sel2 = int'($urandom_range(0, 7));
            en0 = 1'($urandom_range(0, 1));    en2 = 1'($urandom_range(0, 1));
            c0 = longint'($urandom_range(0, 12)); c2 = longint'($urandom_range(0, 12));
            s0 = longint'($urandom_range(0, 10)); s2 = longint'($urandom_range(0, 10));
            m = int'($urandom_range(0, 700));
            ctl0 = 32'(sel0) | (en0 ? 32'h20 : 32'h0);
            ctl2 = 32'(sel2) | (en2 ? 32'h20 : 32'h0);
            wr(a_reg(0, 0), 32'(c0)); wr(a_reg(0, 1), 32'(s0)); wr(a_reg(0, 2), ctl0);
            wr(a_reg(2, 0), 32'(c2)); wr(a_reg(2, 1), 32'(s2)); wr(a_reg(2, 2), ctl2);
            wr(8'h00, 32'h5);
            idle(m);
            wr(8'h00, 32'h0);
            t0 = longint'(m + 2) / divisor(sel0);
            t2 = longint'(m + 2) / divisor(sel2);
            u0 = exp_uflows(s0, c0, t0);
            u2 = exp_uflows(s2, c2, t2);
            rd(a_reg(0, 1), v); check("R4 ch0 count", v, exp_count(s0, c0, t0));
            rd(a_reg(2, 1), v); check("R4 ch2 count", v, exp_count(s2, c2, t2));
            rd(a_reg(0, 2), v); check("R5 ch0 flag", v, ctl0 | (u0 > 0 ? 32'h100 : 32'h0));
            rd(a_reg(2, 2), v); check("R5 ch2 flag", v, ctl2 | (u2 > 0 ? 32'h100 : 32'h0));
            check("R8 irq0", 32'(irq[0]), 32'(en0 && u0 > 0));
            check("R8 irq2", 32'(irq[2]), 32'(en2 && u2 > 0));
        end
        rd(a_reg(1, 1), v); check("R3 untouched channel", v, hold1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule